// File: doc/BRIEF.md
# Receiver Wake-Up Duty-Cycle Sequencer

This block paces a radio receiver through a polled-listening cycle. It keeps the receiver powered down for a programmable number of slow ticks, then powers it up for a programmable number of ticks, and repeats. The ticks come from a divider on the crystal reference, so the listening duty cycle is set accurately. If the data path reports a message in progress when an on window runs out, the receiver stays up until the message has been taken in.

A host can take over at any moment through a strobe that is either released or driven. Driven low, it keeps the receiver down. Driven high, it keeps the receiver up. Released, it hands pacing back to the internal timer. An active-low configuration input parks the block in a configuration state with the receiver down. Two configuration banks can take turns: each on window belongs to one bank, and with both banks enabled successive windows alternate between them without any host traffic.

Top module: `rx_wake_seq`

## Requirements
- R1: While rst_ni is low and after it is released, with cfg_ni still low, state_o is 0 (configuration), rx_en_o is 0 and bank_o is 0 (bank A).
- R2: When cfg_ni goes low, the third clock edge that follows puts state_o to 0, rx_en_o to 0 and bank_o to 0. This holds whatever the strobe inputs do.
- R3: An off window (state_o = 1, rx_en_o = 0) lasts exactly max(off_len_i, 1) ticks, counted from entry into the window.
- R4: An on window (state_o = 2, rx_en_o = 1) lasts exactly max(on_len_i, 1) ticks. A zero setting counts as one tick, so the cycle never stalls.
- R5: If msg_act_i is high when the on window expires, the block enters the hold state (state_o = 3) and rx_en_o stays 1 across further ticks. The first tick seen with msg_act_i low ends the window.
- R6: With strb_drv_i high and strb_lvl_i low, the third clock edge gives state_o = 4 and rx_en_o = 0. Ticks have no effect while this lasts.
- R7: With strb_drv_i high and strb_lvl_i high, the third clock edge gives state_o = 5 and rx_en_o = 1, whatever the timer was doing.
- R8: When the strobe is released (strb_drv_i low), the block enters an off window with a full off count. It enters the hold state instead if it was forced on and msg_act_i is high.
- R9: With both banks enabled, on windows alternate A, B, A, and so on, starting with A after configuration. bank_o (0 = A, 1 = B) switches when an on window ends, so during an off window it shows the bank of the next on window.
- R10: With one bank enabled, every on window uses that bank. With only B enabled, bank_o changes from 0 to 1 at the end of the first off window.
- R11: With neither bank enabled, the block stays in off windows and rx_en_o stays 0.
- R12: Outside strobe override and configuration, rx_en_o changes only at a clock edge where tick_i is high.
- R13: state_o encodes 0 configuration, 1 off, 2 on, 3 hold for message, 4 forced off, 5 forced on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse from the reference divider; the unit of both windows |
| cfg_ni | input | 1 | Active-low configuration select, asynchronous |
| strb_drv_i | input | 1 | Strobe is driven by the host (0 = released), asynchronous |
| strb_lvl_i | input | 1 | Level of the driven strobe, asynchronous |
| bank_a_en_i | input | 1 | Bank A takes part in the cycle |
| bank_b_en_i | input | 1 | Bank B takes part in the cycle |
| on_len_i | input | RON_W | On window length in ticks (0 counts as 1) |
| off_len_i | input | ROFF_W | Off window length in ticks (0 counts as 1) |
| msg_act_i | input | 1 | A valid message is being received |
| rx_en_o | output | 1 | Receiver power enable |
| bank_o | output | 1 | Active bank, 0 = A, 1 = B |
| state_o | output | 3 | Sequencer state code |

## Verification
Random trials draw both window lengths over their full ranges, including zero, together with one of the three bank-enable combinations and a random spacing between ticks. Each tick's observed receiver level and bank are compared with the expected periodic pattern. These trials tell a wrong reload or off-by-one count apart from a wrong bank rotation, and the spacing shows whether the output moves between ticks. Directed cases cover message hold across expiry, each strobe override and its release, configuration taking priority over a driven strobe, and the case with no bank enabled. These separate the override priorities from the timer path.

// File: rtl/rws_pkg.sv
package rws_pkg;
  typedef enum logic [2:0] {
    ST_CONF = 3'd0,
    ST_OFF  = 3'd1,
    ST_ON   = 3'd2,
    ST_HOLD = 3'd3,
    ST_FOFF = 3'd4,
    ST_FON  = 3'd5
  } rws_state_e;

  function automatic logic rx_powered(rws_state_e s);
    return (s == ST_ON) || (s == ST_HOLD) || (s == ST_FON);
  endfunction
endpackage

// File: rtl/rws_sync.sv
module rws_sync #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= RST_VAL;
    else         stg_q[0] <= d_i;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[i] <= RST_VAL;
      else         stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/rws_timer.sv
module rws_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             run_i,
  input  logic             tick_i,
  output logic             expire_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] ld_val;

  // zero setting behaves as a single tick
  assign ld_val   = (load_val_i == '0) ? ONE : load_val_i;
  assign expire_o = run_i && tick_i && (cnt_q == ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= ONE;
    else if (load_i)                    cnt_q <= ld_val;
    else if (run_i && tick_i && cnt_q != ONE) cnt_q <= cnt_q - ONE;
  end

  AST_CNT_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q != '0); // R4
endmodule

// File: rtl/rws_bank.sv
module rws_bank (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_a_i,
  input  logic en_b_i,
  input  logic clr_i,
  input  logic adv_i,
  input  logic pick_i,
  output logic bank_o,
  output logic any_o
);
  logic bank_q;
  logic cur_en, oth_en;

  assign cur_en = bank_q ? en_b_i : en_a_i;
  assign oth_en = bank_q ? en_a_i : en_b_i;
  assign any_o  = en_a_i || en_b_i;
  assign bank_o = bank_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          bank_q <= 1'b0;
    else if (clr_i)                       bank_q <= 1'b0;
    else if (adv_i && oth_en)             bank_q <= ~bank_q;
    else if (pick_i && !cur_en && oth_en) bank_q <= ~bank_q;
  end

  AST_BANK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !adv_i && !pick_i) |=> $stable(bank_q)); // R9
endmodule

// File: rtl/rx_wake_seq.sv
module rx_wake_seq #(
  parameter int RON_W       = 4,
  parameter int ROFF_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              cfg_ni,
  input  logic              strb_drv_i,
  input  logic              strb_lvl_i,
  input  logic              bank_a_en_i,
  input  logic              bank_b_en_i,
  input  logic [RON_W-1:0]  on_len_i,
  input  logic [ROFF_W-1:0] off_len_i,
  input  logic              msg_act_i,
  output logic              rx_en_o,
  output logic              bank_o,
  output logic [2:0]        state_o
);
  import rws_pkg::*;

  localparam int CNT_W = (RON_W > ROFF_W) ? RON_W : ROFF_W;

  logic [2:0] async_s;
  logic       cfg_s, strb_drv_s, strb_lvl_s;

  rws_state_e       st_q, st_d;
  logic             load, adv, pick, expire, run, any_en;
  logic [CNT_W-1:0] load_val;

  // reset value keeps configuration asserted until the first synced sample
  rws_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b000)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cfg_ni, strb_drv_i, strb_lvl_i}),
    .q_o   (async_s)
  );
  assign {cfg_s, strb_drv_s, strb_lvl_s} = async_s;

  assign run = (st_q == ST_OFF) || (st_q == ST_ON);

  rws_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .load_val_i(load_val),
    .run_i     (run),
    .tick_i    (tick_i),
    .expire_o  (expire)
  );

  rws_bank u_bank (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_a_i(bank_a_en_i),
    .en_b_i(bank_b_en_i),
    .clr_i (!cfg_s),
    .adv_i (adv),
    .pick_i(pick),
    .bank_o(bank_o),
    .any_o (any_en)
  );

  always_comb begin
    st_d     = st_q;
    load     = 1'b0;
    load_val = CNT_W'(off_len_i);
    adv      = 1'b0;
    pick     = 1'b0;
    if (!cfg_s) begin
      st_d = ST_CONF;
    end else if (strb_drv_s && !strb_lvl_s) begin
      st_d = ST_FOFF;
    end else if (strb_drv_s) begin
      st_d = ST_FON;
    end else begin
      unique case (st_q)
        ST_CONF, ST_FOFF: begin
          st_d = ST_OFF;
          load = 1'b1;
        end
        ST_FON: begin
          if (msg_act_i) st_d = ST_HOLD;
          else begin
            st_d = ST_OFF;
            load = 1'b1;
          end
        end
        ST_OFF: begin
          if (expire) begin
            pick = 1'b1;
            load = 1'b1;
            if (any_en) begin
              st_d     = ST_ON;
              load_val = CNT_W'(on_len_i);
            end
          end
        end
        ST_ON: begin
          if (expire) begin
            if (msg_act_i) st_d = ST_HOLD;
            else begin
              st_d = ST_OFF;
              load = 1'b1;
              adv  = 1'b1;
            end
          end
        end
        ST_HOLD: begin
          if (tick_i && !msg_act_i) begin
            st_d = ST_OFF;
            load = 1'b1;
            adv  = 1'b1;
          end
        end
        default: st_d = ST_CONF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_CONF;
    else         st_q <= st_d;
  end

  assign rx_en_o = rx_powered(st_q);
  assign state_o = st_q;

  AST_CFG_FORCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_s |=> (state_o == 3'd0) && !rx_en_o); // R2
  AST_STRB_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_s && strb_drv_s && !strb_lvl_s) |=> !rx_en_o); // R6
  AST_STRB_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_s && strb_drv_s && strb_lvl_s) |=> rx_en_o); // R7
  AST_HOLD_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_s && !strb_drv_s && st_q == ST_HOLD && msg_act_i) |=> rx_en_o); // R5
  AST_TICK_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_s && !strb_drv_s && !tick_i &&
     (st_q == ST_OFF || st_q == ST_ON || st_q == ST_HOLD)) |=> $stable(rx_en_o)); // R12
  AST_NO_BANK_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_s && !strb_drv_s && !bank_a_en_i && !bank_b_en_i && st_q == ST_OFF)
      |=> !rx_en_o); // R11
endmodule

// File: tb/sim_rx_wake_seq.sv
module sim_rx_wake_seq;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       cfg_ni = 1'b0;
  logic       strb_drv_i = 1'b0;
  logic       strb_lvl_i = 1'b0;
  logic       bank_a_en_i = 1'b1;
  logic       bank_b_en_i = 1'b0;
  logic [3:0] on_len_i = 4'd1;
  logic [2:0] off_len_i = 3'd1;
  logic       msg_act_i = 1'b0;
  logic       rx_en_o, bank_o;
  logic [2:0] state_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  rx_wake_seq u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .cfg_ni(cfg_ni),
    .strb_drv_i(strb_drv_i), .strb_lvl_i(strb_lvl_i),
    .bank_a_en_i(bank_a_en_i), .bank_b_en_i(bank_b_en_i),
    .on_len_i(on_len_i), .off_len_i(off_len_i), .msg_act_i(msg_act_i),
    .rx_en_o(rx_en_o), .bank_o(bank_o), .state_o(state_o)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int eff(int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic int exp_rx(int i, int roff, int ron, bit ea, bit eb);
    if (!ea && !eb) return 0;
    return ((i % (roff + ron)) >= roff) ? 1 : 0;
  endfunction

  function automatic int exp_bank(int i, int roff, int ron, bit ea, bit eb);
    if (ea && eb) return (i / (roff + ron)) % 2;
    if (eb) return (i < roff) ? 0 : 1;
    return 0;
  endfunction

  // one tick pulse, then gap idle cycles checking the output holds (R12)
  task automatic do_tick(int gap, output int rx_pre, output int bk_pre, output int rx_post);
    rx_pre = int'(rx_en_o);
    bk_pre = int'(bank_o);
    tick_i = 1'b1;
    @(negedge clk_i);
    tick_i = 1'b0;
    rx_post = int'(rx_en_o);
    for (int g = 0; g < gap; g++) begin
      @(negedge clk_i);
      chk("R12 rx stable between ticks", int'(rx_en_o), rx_post);
    end
  endtask

  task automatic enter_cfg();
    cfg_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    chk("R2 state after config", int'(state_o), 0);
    chk("R2 rx after config", int'(rx_en_o), 0);
    chk("R2 bank after config", int'(bank_o), 0);
  endtask

  task automatic leave_cfg();
    cfg_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    chk("R3 off state after config exit", int'(state_o), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int rp, bp, ra;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk_i);
    chk("R1 reset state", int'(state_o), 0);
    chk("R1 reset rx", int'(rx_en_o), 0);
    chk("R1 reset bank", int'(bank_o), 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    chk("R1 config held after reset", int'(state_o), 0);

    // random trials: R3 R4 R9 R10 R11 R12
    for (int t = 0; t < 24; t++) begin
      int ron, roff, gap, sel, n;
      bit ea, eb;
      ron  = int'($urandom_range(0, 15));
      roff = int'($urandom_range(0, 7));
      if (t < 2) begin ron = 0; roff = 0; end
      sel  = int'($urandom_range(0, 2));
      if (t == 3) sel = 3;
      ea = (sel == 0) || (sel == 2);
      eb = (sel == 1) || (sel == 2);
      gap = int'($urandom_range(0, 3));
      enter_cfg();
      on_len_i = 4'(ron); off_len_i = 3'(roff);
      bank_a_en_i = ea; bank_b_en_i = eb;
      leave_cfg();
      n = 3 * (eff(ron) + eff(roff));
      for (int i = 0; i < n; i++) begin
        do_tick(gap, rp, bp, ra);
        chk("R3 R4 R11 rx per tick", rp, exp_rx(i, eff(roff), eff(ron), ea, eb));
        chk("R9 R10 bank per tick", bp, exp_bank(i, eff(roff), eff(ron), ea, eb));
      end
    end

    // message hold R5
    enter_cfg();
    on_len_i = 4'd2; off_len_i = 3'd1; bank_a_en_i = 1'b1; bank_b_en_i = 1'b0;
    leave_cfg();
    do_tick(1, rp, bp, ra);
    chk("R4 on after off window", ra, 1);
    msg_act_i = 1'b1;
    do_tick(1, rp, bp, ra);
    do_tick(1, rp, bp, ra);
    chk("R5 hold state at expiry", int'(state_o), 3);
    for (int k = 0; k < 3; k++) begin
      do_tick(1, rp, bp, ra);
      chk("R5 rx held during message", ra, 1);
    end
    msg_act_i = 1'b0;
    do_tick(1, rp, bp, ra);
    chk("R5 off after message end", ra, 0);
    chk("R13 off code", int'(state_o), 1);

    // strobe overrides R6 R7 R8
    off_len_i = 3'd3;
    do_tick(1, rp, bp, ra);
    chk("R4 on again", ra, 1);
    strb_drv_i = 1'b1; strb_lvl_i = 1'b0;
    repeat (3) @(negedge clk_i);
    chk("R6 forced off code", int'(state_o), 4);
    chk("R6 forced off rx", int'(rx_en_o), 0);
    for (int k = 0; k < 4; k++) begin
      do_tick(0, rp, bp, ra);
      chk("R6 ticks ignored while forced off", ra, 0);
    end
    strb_lvl_i = 1'b1;
    repeat (3) @(negedge clk_i);
    chk("R7 forced on code", int'(state_o), 5);
    chk("R7 forced on rx", int'(rx_en_o), 1);
    strb_drv_i = 1'b0;
    repeat (3) @(negedge clk_i);
    chk("R8 release to off", int'(state_o), 1);
    do_tick(0, rp, bp, ra);
    do_tick(0, rp, bp, ra);
    chk("R8 full off count kept", ra, 0);
    do_tick(0, rp, bp, ra);
    chk("R8 on after full off count", ra, 1);

    // config priority over driven strobe R2
    strb_drv_i = 1'b1; strb_lvl_i = 1'b1;
    repeat (3) @(negedge clk_i);
    chk("R7 forced on before config", int'(rx_en_o), 1);
    enter_cfg();
    strb_drv_i = 1'b0;

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule